// File: doc/BRIEF.md
# Fracturable Four-Input Logic Element

This block is the basic logic element of a programmable fabric. Its truth-table store can act as one 4-input lookup table or be split into two 3-input tables that share their three low inputs. A hard single-bit full adder sits behind the tables. Its carry input and carry output let eight elements in a cluster form a ripple chain. Each of the two outputs has its own flip-flop, and a configuration bit chooses whether that output is registered or passed straight through.

All settings come from one configuration word. The word holds a mode code, two output-register selects and a 16-bit truth table. It is loaded serially while the configuration enable is high, one bit per clock, most significant bit first. The logic outputs are undefined while the word is shifting in. Routing and the cluster crossbar sit outside this block.

Top module: `ble4_frac`

## Requirements
- R1: The 21-bit configuration word shifts in at `cfg_in` on each rising edge where `cfg_en` is high, most significant bit first. Bits [20:18] hold the mode code. Bit 17 registers output A, bit 16 registers output B, and bits [15:0] hold the truth table T.
- R2: While `rst` is high at a rising edge, both flip-flops clear, so any registered output reads 0 after that edge.
- R3: Mode 1 is the single LUT4. Output A equals T[din], with din read as a 4-bit index. Output B and `cout` are 0.
- R4: Mode 2 is a single LUT3. Output A equals T[din[2:0]], taken from the low half of T. Output B and `cout` are 0.
- R5: Mode 3 is a LUT3 feeding the adder. The operands are x = T[din[2:0]] and y = din[3]. Output A is x^y^cin, `cout` is the majority of x, y and cin, and output B is 0.
- R6: Mode 4 is two LUT3s. Output A equals T[din[2:0]] and output B equals T[8+din[2:0]]. `cout` is 0.
- R7: Mode 5 is two LUT3s feeding the adder. The operands are x = T[din[2:0]] and y = T[8+din[2:0]]. Output A is the sum x^y^cin, and both output B and `cout` equal the majority of x, y and cin.
- R8: When an output's register select is 1, that output shows the value its flip-flop captured at the last rising edge. When the select is 0, the output follows its inputs combinationally.
- R9: Mode codes 0, 6 and 7 switch the element off. Both outputs and `cout` are then 0.
- R10: `cout` is 0 in every mode that does not use the adder. It is never registered, so it can drive the next element's `cin` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flops and the configuration register |
| rst | input | 1 | Synchronous active-high clear of both flip-flops |
| cfg_en | input | 1 | Enables shifting of the configuration word |
| cfg_in | input | 1 | Serial configuration data, MSB first |
| din | input | 4 | Logic inputs; din[3] is the top table index bit |
| cin | input | 1 | Carry input from the previous element |
| out_a | output | 1 | Output A (LUT4, table A or sum) |
| out_b | output | 1 | Output B (table B or carry), 0 when unused |
| cout | output | 1 | Carry output to the next element |

## Verification
The combinational paths, including `cout`, settle within the cycle the inputs are applied. A registered output shows a vector's result only after the next rising edge. The bench drives each vector on a falling edge and immediately checks that every registered output still holds the previous vector's result. A scoreboard entry is popped just after the following rising edge, and by then both combinational and registered outputs must match the vector's own result. Every mode runs with all four register-select combinations over all 32 values of din and cin, each time with a fresh random truth table.

// File: rtl/ble4_frac.sv
module ble4_frac #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_in,
  input  logic [K-1:0] din,
  input  logic         cin,
  output logic         out_a,
  output logic         out_b,
  output logic         cout
);
  localparam int TT_W   = 1 << K;
  localparam int MODE_W = 3;
  localparam int CFG_W  = TT_W + 2 + MODE_W;

  localparam logic [MODE_W-1:0] M_LUT4  = 3'd1;
  localparam logic [MODE_W-1:0] M_LUT3  = 3'd2;
  localparam logic [MODE_W-1:0] M_ADD1  = 3'd3;
  localparam logic [MODE_W-1:0] M_DUAL  = 3'd4;
  localparam logic [MODE_W-1:0] M_ADD2  = 3'd5;

  logic [CFG_W-1:0]  cfg;
  logic [MODE_W-1:0] mode;
  logic              sel_ra, sel_rb;
  logic [TT_W-1:0]   tt;
  logic              lut4, lut_lo, lut_hi, op_y, sum, maj;
  logic              comb_a, comb_b, carry;
  logic              ff_a, ff_b;

  always_ff @(posedge clk)
    if (cfg_en) cfg <= {cfg[CFG_W-2:0], cfg_in};

  assign mode   = cfg[CFG_W-1 -: MODE_W];
  assign sel_ra = cfg[TT_W+1];
  assign sel_rb = cfg[TT_W];
  assign tt     = cfg[TT_W-1:0];

  assign lut4   = tt[din];
  assign lut_lo = tt[{1'b0, din[K-2:0]}];
  assign lut_hi = tt[{1'b1, din[K-2:0]}];
  assign op_y   = (mode == M_ADD2) ? lut_hi : din[K-1];
  assign sum    = lut_lo ^ op_y ^ cin;
  assign maj    = (lut_lo & op_y) | (lut_lo & cin) | (op_y & cin);

  always_comb begin
    comb_a = 1'b0;
    comb_b = 1'b0;
    carry  = 1'b0;
    case (mode)
      M_LUT4: comb_a = lut4;
      M_LUT3: comb_a = lut_lo;
      M_ADD1: begin comb_a = sum; carry = maj; end
      M_DUAL: begin comb_a = lut_lo; comb_b = lut_hi; end
      M_ADD2: begin comb_a = sum; comb_b = maj; carry = maj; end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (rst) begin
      ff_a <= 1'b0;
      ff_b <= 1'b0;
    end else begin
      ff_a <= comb_a;
      ff_b <= comb_b;
    end

  assign out_a = sel_ra ? ff_a : comb_a;
  assign out_b = sel_rb ? ff_b : comb_b;
  assign cout  = carry;

  assert_ff_clear_R2: assert property (@(posedge clk) rst |=> (!ff_a && !ff_b));

  assert_reg_a_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && sel_ra) |=> (out_a == $past(comb_a)));

  assert_reg_b_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && sel_rb) |=> (out_b == $past(comb_b)));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && (mode == 3'd0 || mode > M_ADD2)) |=> (!out_a && !out_b && !cout));

  always_comb
    if (mode != M_ADD1 && mode != M_ADD2)
      assert_no_carry_R10: assert (cout == 1'b0);

  always_comb
    if (mode == M_LUT4 || mode == M_LUT3 || mode == M_ADD1)
      assert_b_idle_R3: assert (comb_b == 1'b0);
endmodule

// File: tb/ble4_frac_tb.sv
`timescale 1ns/1ps
module ble4_frac_tb;
  logic clk = 1'b0, rst = 1'b0, cfg_en = 1'b0, cfg_in = 1'b0, cin = 1'b0;
  logic [3:0] din = 4'd0;
  logic out_a, out_b, cout;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct packed { logic a; logic b; logic co; logic [2:0] mode; } exp_t;
  exp_t q[$];

  ble4_frac u_dut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
                   .din(din), .cin(cin), .out_a(out_a), .out_b(out_b), .cout(cout));

  always #2.5 clk = ~clk;

  function automatic logic [2:0] model(input logic [2:0] m, input logic [15:0] t,
                                       input logic [3:0] d, input logic c);
    logic x, y, s, mj;
    x = t[{1'b0, d[2:0]}];
    y = (m == 3'd5) ? t[{1'b1, d[2:0]}] : d[3];
    s = x ^ y ^ c;
    mj = (x & y) | (x & c) | (y & c);
    case (m)
      3'd1: return {t[d], 2'b00};
      3'd2: return {x, 2'b00};
      3'd3: return {s, 1'b0, mj};
      3'd4: return {x, t[{1'b1, d[2:0]}], 1'b0};
      3'd5: return {s, mj, mj};
      default: return 3'b000;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {a,b,cout} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // R1: word {mode[2:0], reg_a, reg_b, table[15:0]} shifted MSB first
  task automatic load_cfg(input logic [2:0] m, input logic ra, input logic rb, input logic [15:0] t);
    logic [20:0] w;
    w = {m, ra, rb, t};
    for (int i = 20; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(req_of(e.mode), {out_a, out_b, cout}, {e.a, e.b, e.co});
    end
  end

  task automatic run_mode(input logic [2:0] m, input logic ra, input logic rb);
    logic [15:0] t;
    logic [2:0] prev, cur;
    t = 16'($urandom());
    load_cfg(m, ra, rb, t);
    prev = 3'b000;
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      din = 4'(v);
      cin = v[4];
      cur = model(m, t, din, cin);
      q.push_back({cur[2], cur[1], cur[0], m});
      #1;
      if (v > 0) // R8: registered outputs still show the previous result
        check("R8", {out_a, out_b, cout},
              {ra ? prev[2] : cur[2], rb ? prev[1] : cur[1], cur[0]});
      prev = cur;
    end
    @(negedge clk);
  endtask

  initial begin
    // R2: registered outputs clear under reset
    load_cfg(3'd4, 1'b1, 1'b1, 16'hFFFF);
    din = 4'd3;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #0.5;
    check("R2", {out_a, out_b, cout}, 3'b000);
    // R1: load a LUT4 word whose first-shifted bits pick the mode
    load_cfg(3'd1, 1'b0, 1'b0, 16'h8000);
    din = 4'hF; #0.5;
    check("R1", {out_a, out_b, cout}, 3'b100);
    din = 4'hE; #0.5;
    check("R1", {out_a, out_b, cout}, 3'b000);
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 4; r++)
        run_mode(3'(m), r[1], r[0]); // R3..R7, R9, R10 via scoreboard
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule